// File: doc/BRIEF.md
# Interrupt Context Exchange Unit

This unit swaps the whole architectural context of a processor with a block in memory when an interrupt arrives. The context is eight scalar registers, eight address registers, the program counter and the monitor flags. The unit packs all of it into sixteen memory words. It writes that block over the old one while it reads the replacement context from the same addresses. The block's base address is held in a dedicated exchange base register, which may be rewritten only while the unit is quiet.

During an exchange the unit holds a stall output high, so the pipeline stays frozen. The swap works in place. For each word, in ascending address order, one read cycle on a simple synchronous memory port is followed by one write cycle to the same address. After the last write, a one-cycle done pulse marks the end. At the same moment the incoming register values, flags and restart program counter appear on registered outputs, ready for the register file to load.

Top module: `ctx_exchange`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done` and `mem_en` are 0, and `restart_pc`, `new_flags`, `new_sreg` and `new_areg` are 0.
- R2: An `irq` sampled high at a clock edge while `busy` is low makes `busy` high after that edge. In the same cycle the memory port shows a read (`mem_en`=1, `mem_we`=0) at the exchange base address.
- R3: An exchange issues exactly 16 reads and 16 writes. Each read of address base+k is followed in the next cycle by a write to base+k, and that write is followed by the read of base+k+1 or, after k=15, by `mem_en`=0. Memory returns read data one cycle after an enabled read, so word k is read before it is overwritten.
- R4: The outgoing block has this layout. Word 0 holds the PC in bits [23:0] and the flags in bits [31:24], with the upper bits zero. Word 1+i holds scalar register i (i=0..7). Word 9+j holds address register j zero-extended (j=0..5). Word 15 holds address register 6 in bits [23:0] and address register 7 in bits [47:24].
- R5: When `done` is high, `new_sreg`, `new_areg` and `new_flags` hold the fields of the sixteen words read from memory, decoded with the R4 layout. Bits that R4 leaves unused are ignored.
- R6: `done` is a single-cycle pulse. It rises 33 clock edges after the edge that started the exchange, which is two cycles after the last write cycle on the port. `restart_pc` takes the PC field of incoming word 0 in that same cycle.
- R7: An `irq` seen while `busy` is high is held pending. `busy` stays high through the `done` cycle, and a second exchange starts at the next edge, so its `done` follows the first by 34 cycles.
- R8: A write on `base_we` takes effect only at an edge where `busy` and `irq` are both low. Otherwise it is ignored, and the next exchange uses the old base.
- R9: `mem_en` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request that starts an exchange |
| base_we | input | 1 | Write strobe for the exchange base register |
| base_wdata | input | 16 | New exchange base address |
| cur_sreg | input | 512 | Live scalar registers, register i at [64*i +: 64] |
| cur_areg | input | 192 | Live address registers, register j at [24*j +: 24] |
| cur_pc | input | 24 | Live program counter |
| cur_flags | input | 8 | Live monitor flags |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after an enabled read |
| busy | output | 1 | Exchange active or pending; stalls the pipeline |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| restart_pc | output | 24 | Program counter to resume from |
| new_flags | output | 8 | Incoming monitor flags |
| new_sreg | output | 512 | Incoming scalar registers |
| new_areg | output | 192 | Incoming address registers |

## Verification
The port properties assume that reset is asserted first and that the memory returns data exactly one cycle after an enabled read. They also assume the memory's read data reflects the contents before a same-cycle write, although the properties themselves only watch the enable, write and address pins and the stall and done flags. The stimulus uses a read-first memory model with that one-cycle latency, and places every block fully inside the model's range. Requests and base writes are driven between clock edges, and the live context is held steady while the stall is high.

// File: rtl/ctx_xchg_pkg.sv
package ctx_xchg_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_READ = 2'd1,
    XS_WRITE = 2'd2,
    XS_FINISH = 2'd3
  } xchg_state_e;
endpackage

// File: rtl/ctx_pack.sv
module ctx_pack #(
  parameter int NSREG  = 8,
  parameter int NAREG  = 8,
  parameter int WORD_W = 64,
  parameter int SREG_W = 64,
  parameter int AREG_W = 24,
  parameter int PC_W   = 24,
  parameter int FLAG_W = 8,
  localparam int NWORD = NSREG + NAREG
) (
  input  logic [NSREG*SREG_W-1:0] sreg,
  input  logic [NAREG*AREG_W-1:0] areg,
  input  logic [PC_W-1:0]         pc,
  input  logic [FLAG_W-1:0]       flags,
  output logic [NWORD*WORD_W-1:0] words
);
  // word 0: control word, flags above the PC
  assign words[0 +: WORD_W] = WORD_W'({flags, pc});

  // scalar registers, one per word
  for (genvar i = 0; i < NSREG; i++) begin : g_sreg
    assign words[(1 + i)*WORD_W +: WORD_W] = WORD_W'(sreg[i*SREG_W +: SREG_W]);
  end

  // address registers, one per word except the last two
  for (genvar j = 0; j < NAREG - 2; j++) begin : g_areg
    assign words[(1 + NSREG + j)*WORD_W +: WORD_W] = WORD_W'(areg[j*AREG_W +: AREG_W]);
  end

  // final word carries the last two address registers side by side
  assign words[(NWORD-1)*WORD_W +: WORD_W] =
    WORD_W'({areg[(NAREG-1)*AREG_W +: AREG_W], areg[(NAREG-2)*AREG_W +: AREG_W]});
endmodule

// File: rtl/ctx_unpack.sv
module ctx_unpack #(
  parameter int NSREG  = 8,
  parameter int NAREG  = 8,
  parameter int WORD_W = 64,
  parameter int SREG_W = 64,
  parameter int AREG_W = 24,
  parameter int PC_W   = 24,
  parameter int FLAG_W = 8,
  localparam int NWORD = NSREG + NAREG
) (
  input  logic [NWORD*WORD_W-1:0] words,
  output logic [NSREG*SREG_W-1:0] sreg,
  output logic [NAREG*AREG_W-1:0] areg,
  output logic [PC_W-1:0]         pc,
  output logic [FLAG_W-1:0]       flags
);
  logic unused_fold;
  assign unused_fold = ^words;

  assign pc    = words[0 +: PC_W];
  assign flags = words[PC_W +: FLAG_W];

  for (genvar i = 0; i < NSREG; i++) begin : g_sreg
    assign sreg[i*SREG_W +: SREG_W] = words[(1 + i)*WORD_W +: SREG_W];
  end

  for (genvar j = 0; j < NAREG - 2; j++) begin : g_areg
    assign areg[j*AREG_W +: AREG_W] = words[(1 + NSREG + j)*WORD_W +: AREG_W];
  end

  assign areg[(NAREG-2)*AREG_W +: AREG_W] = words[(NWORD-1)*WORD_W +: AREG_W];
  assign areg[(NAREG-1)*AREG_W +: AREG_W] = words[(NWORD-1)*WORD_W + AREG_W +: AREG_W];
endmodule

// File: rtl/ctx_xchg_base.sv
module ctx_xchg_base #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  input  logic              irq,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= ADDR_W'(BASE_INIT);
    end else if (we && !busy && !irq) begin
      base <= wdata;
    end
  end
endmodule

// File: rtl/ctx_xchg_ctrl.sv
module ctx_xchg_ctrl
  import ctx_xchg_pkg::*;
#(
  parameter int NWORD  = 16,
  parameter int WORD_W = 64,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(NWORD)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    irq,
  input  logic [ADDR_W-1:0]       base,
  input  logic [NWORD*WORD_W-1:0] out_words,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic                    busy,
  output logic                    done,
  output logic                    commit,
  output logic [NWORD*WORD_W-1:0] in_words
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORD - 1);

  xchg_state_e       state, state_n;
  logic [IDX_W-1:0]  idx;
  logic              pend, pend_n, start;
  logic [WORD_W-1:0] slot [NWORD];

  assign start  = (state == XS_IDLE) && (irq || pend);
  assign commit = (state == XS_FINISH);

  always_comb begin
    state_n = state;
    unique case (state)
      XS_IDLE:   if (start) state_n = XS_READ;
      XS_READ:   state_n = XS_WRITE;
      XS_WRITE:  state_n = (idx == LAST_IDX) ? XS_FINISH : XS_READ;
      XS_FINISH: state_n = XS_IDLE;
      default:   state_n = XS_IDLE;
    endcase
    pend_n = (pend || irq) && !start;
  end

  // control and memory port, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      idx       <= '0;
      pend      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state <= state_n;
      pend  <= pend_n;
      busy  <= (state_n != XS_IDLE) || pend_n;
      done  <= (state == XS_FINISH);
      unique case (state)
        XS_IDLE: begin
          if (start) begin
            idx      <= '0;
            mem_en   <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= base;
          end
        end
        XS_READ: begin
          mem_we    <= 1'b1;
          mem_wdata <= slot[idx];
        end
        XS_WRITE: begin
          mem_we <= 1'b0;
          if (idx == LAST_IDX) begin
            mem_en <= 1'b0;
          end else begin
            idx      <= idx + IDX_W'(1);
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // staging words: snapshot on start, swapped in place per word
  always_ff @(posedge clk) begin
    if (state == XS_IDLE && start) begin
      for (int k = 0; k < NWORD; k++) begin
        slot[k] <= out_words[k*WORD_W +: WORD_W];
      end
    end else if (state == XS_WRITE) begin
      slot[idx] <= mem_rdata;
    end
  end

  for (genvar k = 0; k < NWORD; k++) begin : g_flat
    assign in_words[k*WORD_W +: WORD_W] = slot[k];
  end
endmodule

// File: rtl/ctx_exchange.sv
module ctx_exchange #(
  parameter int          NSREG     = 8,
  parameter int          NAREG     = 8,
  parameter int          WORD_W    = 64,
  parameter int          SREG_W    = 64,
  parameter int          AREG_W    = 24,
  parameter int          PC_W      = 24,
  parameter int          FLAG_W    = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_INIT = 16'h0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    irq,
  input  logic                    base_we,
  input  logic [ADDR_W-1:0]       base_wdata,
  input  logic [NSREG*SREG_W-1:0] cur_sreg,
  input  logic [NAREG*AREG_W-1:0] cur_areg,
  input  logic [PC_W-1:0]         cur_pc,
  input  logic [FLAG_W-1:0]       cur_flags,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic [PC_W-1:0]         restart_pc,
  output logic [FLAG_W-1:0]       new_flags,
  output logic [NSREG*SREG_W-1:0] new_sreg,
  output logic [NAREG*AREG_W-1:0] new_areg
);
  localparam int NWORD = NSREG + NAREG;

  logic [ADDR_W-1:0]       base;
  logic [NWORD*WORD_W-1:0] out_words, in_words;
  logic                    commit;
  logic [NSREG*SREG_W-1:0] dec_sreg;
  logic [NAREG*AREG_W-1:0] dec_areg;
  logic [PC_W-1:0]         dec_pc;
  logic [FLAG_W-1:0]       dec_flags;

  ctx_xchg_base #(.ADDR_W(ADDR_W), .BASE_INIT(BASE_INIT)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata),
    .busy(busy), .irq(irq), .base(base)
  );

  ctx_pack #(.NSREG(NSREG), .NAREG(NAREG), .WORD_W(WORD_W), .SREG_W(SREG_W),
             .AREG_W(AREG_W), .PC_W(PC_W), .FLAG_W(FLAG_W)) u_pack (
    .sreg(cur_sreg), .areg(cur_areg), .pc(cur_pc), .flags(cur_flags), .words(out_words)
  );

  ctx_xchg_ctrl #(.NWORD(NWORD), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .irq(irq), .base(base), .out_words(out_words),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .commit(commit), .in_words(in_words)
  );

  ctx_unpack #(.NSREG(NSREG), .NAREG(NAREG), .WORD_W(WORD_W), .SREG_W(SREG_W),
               .AREG_W(AREG_W), .PC_W(PC_W), .FLAG_W(FLAG_W)) u_unpack (
    .words(in_words), .sreg(dec_sreg), .areg(dec_areg), .pc(dec_pc), .flags(dec_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      restart_pc <= '0;
      new_flags  <= '0;
      new_sreg   <= '0;
      new_areg   <= '0;
    end else if (commit) begin
      restart_pc <= dec_pc;
      new_flags  <= dec_flags;
      new_sreg   <= dec_sreg;
      new_areg   <= dec_areg;
    end
  end
endmodule

// File: rtl/ctx_exchange_chk.sv
module ctx_exchange_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_en)); // R1

  AST_IRQ_STALLS: assert property (@(posedge clk) disable iff (rst)
    (irq && !busy) |=> busy); // R2

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> (mem_en && mem_we && mem_addr == $past(mem_addr))); // R3

  AST_NEXT_READ_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> (!mem_en || (!mem_we && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_we, 2) && !$past(mem_en))); // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    irq |=> busy); // R7

  AST_PORT_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en); // R9
endmodule

bind ctx_exchange ctx_exchange_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .busy(busy), .done(done),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/ctx_exchange_bench.sv
module ctx_exchange_bench;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic          base_we = 1'b0;
  logic [15:0]   base_wdata = '0;
  logic [511:0]  cur_sreg;
  logic [191:0]  cur_areg;
  logic [23:0]   cur_pc;
  logic [7:0]    cur_flags;
  logic          mem_en, mem_we, busy, done;
  logic [15:0]   mem_addr;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata = '0;
  logic [23:0]   restart_pc;
  logic [7:0]    new_flags;
  logic [511:0]  new_sreg;
  logic [191:0]  new_areg;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  logic [63:0] sreg_v [8];
  logic [23:0] areg_v [8];
  logic [23:0] pc_v;
  logic [7:0]  fl_v;
  logic [63:0] inw [16];
  logic [63:0] m [64];

  // base address in the upper half, context seed in the lower half
  localparam logic [31:0] VECS [4] = '{
    {16'd0,  16'd1},
    {16'd16, 16'd7},
    {16'd5,  16'd42},
    {16'd48, 16'd99}
  };

  always #2 clk = ~clk;

  ctx_exchange u_ctx_exchange (
    .clk(clk), .rst(rst), .irq(irq), .base_we(base_we), .base_wdata(base_wdata),
    .cur_sreg(cur_sreg), .cur_areg(cur_areg), .cur_pc(cur_pc), .cur_flags(cur_flags),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .restart_pc(restart_pc),
    .new_flags(new_flags), .new_sreg(new_sreg), .new_areg(new_areg)
  );

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      cur_sreg[i*64 +: 64] = sreg_v[i];
      cur_areg[i*24 +: 24] = areg_v[i];
    end
    cur_pc    = pc_v;
    cur_flags = fl_v;
  end

  // read-first synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= m[mem_addr[5:0]];
      if (mem_we) begin
        m[mem_addr[5:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y;
    y = (x ^ (x >> 29)) * 64'hBF58476D1CE4E5B9;
    return y ^ (y >> 31) ^ 64'h5DEECE66D;
  endfunction

  function automatic logic [63:0] exp_word(input int k);
    if (k == 0)      return {32'b0, fl_v, pc_v};
    else if (k <= 8) return sreg_v[k-1];
    else if (k < 15) return {40'b0, areg_v[k-9]};
    else             return {16'b0, areg_v[7], areg_v[6]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_ctx(input int seed);
    logic [63:0] t;
    for (int i = 0; i < 8; i++) begin
      sreg_v[i] = mix(64'(seed * 32 + i));
      t = mix(64'(seed * 32 + 8 + i));
      areg_v[i] = t[23:0];
    end
    t = mix(64'(seed * 32 + 16));
    pc_v = t[23:0];
    fl_v = t[31:24];
  endtask

  task automatic fill_block(input logic [15:0] b, input int seed);
    for (int k = 0; k < 16; k++) begin
      inw[k] = mix(64'(seed * 64 + 100 + k));
      m[6'(b + 16'(k))] = inw[k];
    end
  endtask

  task automatic set_base(input logic [15:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // poke_at: cycle to try a base write (0 = together with irq, <0 none)
  // irq_at: cycle to raise a second request (<0 none)
  task automatic run_xchg(input logic [15:0] exp_base, input int poke_at,
                          input logic [15:0] poke_val, input int irq_at, output int lat);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    irq = 1'b1;
    if (poke_at == 0) begin
      base_we = 1'b1;
      base_wdata = poke_val;
    end
    @(posedge clk); #1;
    irq = 1'b0;
    base_we = 1'b0;
    chk("R2 busy after irq", 64'(busy), 64'd1);
    chk("R2 first access is read", 64'({mem_en, mem_we}), 64'b10);
    chk("R2/R8 first address is base", 64'(mem_addr), 64'(exp_base));
    lat = 0;
    while (!done && lat < 200) begin
      if (lat == poke_at && lat > 0) begin
        base_we = 1'b1;
        base_wdata = poke_val;
      end
      if (lat == irq_at) irq = 1'b1;
      @(posedge clk); #1;
      lat++;
      base_we = 1'b0;
      irq = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int lat;
    set_ctx(0);
    for (int k = 0; k < 64; k++) m[k] = '0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 mem_en in reset", 64'(mem_en), 64'd0);
    chk("R1 restart_pc in reset", 64'(restart_pc), 64'd0);
    chk("R1 new_sreg in reset", 64'(new_sreg[63:0]), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R9 port quiet when idle", 64'(mem_en), 64'd0);

    // vector table: swap with several bases and contexts
    for (int v = 0; v < 4; v++) begin
      logic [15:0] b;
      int seed;
      b = VECS[v][31:16];
      seed = int'(VECS[v][15:0]);
      set_base(b);
      set_ctx(seed);
      fill_block(b, seed + 1000);
      run_xchg(b, -1, 16'd0, -1, lat);
      chk("R6 done latency", 64'(lat), 64'd33);
      chk("R6 restart_pc from word 0", 64'(restart_pc), 64'(inw[0][23:0]));
      chk("R5 new flags", 64'(new_flags), 64'(inw[0][31:24]));
      for (int i = 0; i < 8; i++)
        chk("R5 new scalar reg", new_sreg[i*64 +: 64], inw[1+i]);
      for (int j = 0; j < 6; j++)
        chk("R5 new address reg", 64'(new_areg[j*24 +: 24]), 64'(inw[9+j][23:0]));
      chk("R5 address reg 6 from last word", 64'(new_areg[6*24 +: 24]), 64'(inw[15][23:0]));
      chk("R5 address reg 7 from last word", 64'(new_areg[7*24 +: 24]), 64'(inw[15][47:24]));
      chk("R3 read count", 64'(rd_cnt), 64'd16);
      chk("R3 write count", 64'(wr_cnt), 64'd16);
      for (int k = 0; k < 16; k++)
        chk("R4 packed word in memory", m[6'(b + 16'(k))], exp_word(k));
      @(posedge clk); #1;
      chk("R6 done is one cycle", 64'(done), 64'd0);
      chk("R9 busy low after exchange", 64'(busy), 64'd0);
      chk("R9 port quiet after exchange", 64'(mem_en), 64'd0);
    end

    // R8: base writes while busy or together with irq are ignored
    set_base(16'd8);
    set_ctx(3);
    fill_block(16'd8, 77);
    run_xchg(16'd8, 5, 16'd40, -1, lat);
    chk("R8 exchange ran", 64'(lat), 64'd33);
    run_xchg(16'd8, 0, 16'd50, -1, lat);
    run_xchg(16'd8, -1, 16'd0, -1, lat);
    set_base(16'd24);
    run_xchg(16'd24, -1, 16'd0, -1, lat);

    // R7: request during an exchange is held and served next
    set_ctx(11);
    fill_block(16'd24, 500);
    run_xchg(16'd24, -1, 16'd0, 6, lat);
    chk("R7 first exchange latency", 64'(lat), 64'd33);
    chk("R7 busy held through done", 64'(busy), 64'd1);
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!done && lat < 200);
    chk("R7 second done spacing", 64'(lat), 64'd34);
    chk("R7 swap back restores pc", 64'(restart_pc), 64'(pc_v));
    chk("R7 swap back restores scalar 3", new_sreg[3*64 +: 64], sreg_v[3]);
    chk("R7 swap back restores address 7", 64'(new_areg[7*24 +: 24]), 64'(areg_v[7]));
    @(posedge clk); #1;
    chk("R9 idle after pending served", 64'({busy, mem_en}), 64'd0);

    report();
  end
endmodule